// File: doc/BRIEF.md
# Paged Serial EEPROM Slave on a Two-Wire Bus

This block is a bus slave that behaves like a small paged serial EEPROM on an I2C bus. A fast system clock samples the bus clock and data lines through two-flop synchronizers. Bus starts and stops are found from those synchronized samples, and the slave drives the data line only through an open-drain enable, pulling it low while `sda_oe` is high. A strap input chooses between a narrow addressing mode and a wide one. In narrow mode, one address byte follows the control byte and the control byte's select bits give the upper address bits. In wide mode, two address bytes follow, high byte first, and the select bits must match a device number.

Writes land in a page buffer whose in-page offset wraps. A stop at a byte boundary starts a write cycle that lasts a set number of system clocks. During that cycle the buffer is copied into the memory array and every control byte is refused, so a master can poll until it sees an acknowledge again. Reads use one address counter and serve three forms: current address, random (after a dummy write that loads the address) and sequential (continued while the master acknowledges).

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A control byte is acknowledged only when its bits 7..4 are 1010, the slave is not in a write cycle, and, in wide mode, its bits 3..1 equal DEV_SEL (default 000). Bit 0 selects read (1) or write (0). Any other control byte is not acknowledged, and the slave ignores the bus until the next start.
- R2: With `wide_addr`=0, one address byte follows the control byte, and the location is the low ADDR_W bits of {control bits 3..1, address byte}. With `wide_addr`=1, two address bytes follow, and the location is the low ADDR_W bits of {first byte, second byte}.
- R3: During a write transfer, the slave pulls SDA low (acknowledge) on the ninth clock after each accepted control, address or data byte. It changes its drive only while SCL is low.
- R4: Each data byte of a write goes to the current page (2^PAGE_W bytes, default 16), and only the in-page offset advances. A byte written past the page end wraps to the page start, and a later byte to the same offset replaces an earlier one. Other pages are untouched.
- R5: A stop that directly follows an acknowledged data byte starts a write cycle of WR_CYCLES system clocks. During the cycle every control byte is left unacknowledged. After the cycle the written bytes read back.
- R6: A start or stop that arrives in the middle of a data byte ends the transfer and stores nothing. So does a repeated start after write data. No write cycle follows, so the next control byte is acknowledged at once.
- R7: The address counter holds the location after the last byte read or written, and it rolls over from the top address to 0. A read control byte with no address phase returns the byte at the counter.
- R8: A write control byte plus address bytes, followed by a repeated start and a read control byte, returns the byte at that address.
- R9: While the master acknowledges each read byte, further bytes come from consecutive locations. A master not-acknowledge ends the read, and the slave releases SDA.
- R10: Reset releases SDA, returns the slave to idle with no write cycle pending, and clears the address counter to 0. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock level, asynchronous |
| sda_in | input | 1 | Bus data level as seen on the wire, asynchronous |
| wide_addr | input | 1 | Strap: 1 selects two address bytes, 0 selects one |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
Two functions can collide here: a stop can end a write transfer, and the next control byte can arrive while the resulting write cycle is still running. The bench provokes this by issuing a start and a write control byte right after the stop of a page write, well inside the WR_CYCLES window. It judges the result from the acknowledge bit, which must be high, and then from the read-back data once polling sees an acknowledge again. A second pairing uses an abort stop or a repeated start at a point where a stored byte could still be committed. The bench checks that the following control byte is acknowledged at once and that the old memory byte is unchanged.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4,
  parameter int WR_CYCLES = 1000,
  parameter logic [2:0] DEV_SEL = 3'b000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wide_addr,
  output logic sda_oe
);
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int PAGE = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_AHI, S_ALO, S_WDATA, S_RDATA} state_t;

  logic [1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sync <= 2'b11; sda_sync <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q <= scl_sync[1];
      sda_q <= sda_sync[1];
    end
  end

  wire scl_s = scl_sync[1];
  wire sda_s = sda_sync[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire bus_start = scl_s & scl_q & sda_q & ~sda_s;
  wire bus_stop = scl_s & scl_q & ~sda_q & sda_s;

  state_t state;
  logic [3:0] bitcnt;
  logic ack_phase, mack;
  logic [7:0] shreg, tx, ahi;
  logic [2:0] csel;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE-1:0] wvalid;
  logic [CNT_W-1:0] busy_cnt;
  logic [PAGE_W:0] cidx;
  logic [7:0] mem [MEM_DEPTH];
  logic [7:0] wbuf [PAGE];

  wire busy = busy_cnt != '0;
  wire byte_done = scl_fall & ~ack_phase & (bitcnt == 4'd8);
  wire ctrl_ok = (shreg[7:4] == 4'b1010) && (!wide_addr || shreg[3:1] == DEV_SEL) && !busy;
  wire [ADDR_W-1:0] new_addr = wide_addr ? ADDR_W'({ahi, shreg}) : ADDR_W'({csel, shreg});
  wire [ADDR_W-1:0] next_in_page = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
  wire buf_we = byte_done && state == S_WDATA;
  wire mem_we = busy && !cidx[PAGE_W] && wvalid[cidx[PAGE_W-1:0]];
  wire [7:0] rd_byte = mem[ptr];

  always_ff @(posedge clk) begin
    if (buf_we) wbuf[ptr[PAGE_W-1:0]] <= shreg;
    if (mem_we) mem[{ptr[ADDR_W-1:PAGE_W], cidx[PAGE_W-1:0]}] <= wbuf[cidx[PAGE_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; ack_phase <= 1'b0; mack <= 1'b0;
      shreg <= '0; tx <= '0; ahi <= '0; csel <= '0; ptr <= '0;
      wvalid <= '0; busy_cnt <= '0; cidx <= '0; sda_oe <= 1'b0;
    end else begin
      if (busy) begin
        busy_cnt <= busy_cnt - CNT_W'(1);
        if (!cidx[PAGE_W]) cidx <= cidx + (PAGE_W+1)'(1);
      end
      if (bus_start) begin
        state <= S_CTRL; bitcnt <= '0; ack_phase <= 1'b0; sda_oe <= 1'b0; wvalid <= '0;
      end else if (bus_stop) begin
        if (state == S_WDATA && bitcnt == 4'd1 && !ack_phase && |wvalid && !busy) begin
          busy_cnt <= CNT_W'(WR_CYCLES);
          cidx <= '0;
        end else begin
          wvalid <= '0;
        end
        state <= S_IDLE; bitcnt <= '0; ack_phase <= 1'b0; sda_oe <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (ack_phase) mack <= ~sda_s;
          else begin
            shreg <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
        end
        if (scl_fall) begin
          if (ack_phase) begin
            ack_phase <= 1'b0; bitcnt <= '0; sda_oe <= 1'b0;
            if (state == S_RDATA) begin
              if (mack) begin
                tx <= rd_byte;
                sda_oe <= ~rd_byte[7];
                ptr <= ptr + ADDR_W'(1);
              end else state <= S_IDLE;
            end
          end else if (bitcnt == 4'd8) begin
            ack_phase <= 1'b1;
            case (state)
              S_CTRL:
                if (ctrl_ok) begin
                  sda_oe <= 1'b1; csel <= shreg[3:1]; mack <= 1'b1;
                  state <= shreg[0] ? S_RDATA : (wide_addr ? S_AHI : S_ALO);
                end else state <= S_IDLE;
              S_AHI: begin ahi <= shreg; sda_oe <= 1'b1; state <= S_ALO; end
              S_ALO: begin ptr <= new_addr; wvalid <= '0; sda_oe <= 1'b1; state <= S_WDATA; end
              S_WDATA: begin
                wvalid[ptr[PAGE_W-1:0]] <= 1'b1;
                ptr <= next_in_page;
                sda_oe <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (state == S_RDATA) begin
            tx <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end

  // R3
  ack_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_s);
  // R5
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && state == S_CTRL) |=> !sda_oe);
  // R6
  commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(state) == S_WDATA);
  // R4
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WDATA && $past(state) == S_WDATA) |-> $stable(ptr[ADDR_W-1:PAGE_W]));
  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == S_IDLE) |-> !sda_oe);
endmodule

// File: tb/eeprom_i2c_slave_test.sv
module eeprom_i2c_slave_test;
  localparam int Q = 6;
  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wide = 1'b1;
  wire sda_oe;
  wire sda_line = sda_m & ~sda_oe;
  int errors = 0, checks = 0, cyc = 0;

  always #5 clk = ~clk;

  eeprom_i2c_slave uut (.clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
                        .wide_addr(wide), .sda_oe(sda_oe));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic half; repeat (Q) @(negedge clk); endtask

  task automatic send_bit(input logic b);
    sda_m = b; half; scl_m = 1'b1; half; half; scl_m = 1'b0; half;
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; half; scl_m = 1'b1; half; sda_m = 1'b0; half; scl_m = 1'b0; half;
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; half; scl_m = 1'b1; half; sda_m = 1'b1; half;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; half; scl_m = 1'b1; half; ack = ~sda_line; half; scl_m = 1'b0; half;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; half; scl_m = 1'b1; half; b[i] = sda_line; half; scl_m = 1'b0; half;
    end
    send_bit(~give_ack);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] ctrl_of(input logic wm, input logic [15:0] a, input logic rw);
    return wm ? {7'b1010000, rw} : {4'b1010, a[10:8], rw};
  endfunction

  task automatic addr_set(input logic wm, input logic [15:0] a, output logic ok);
    logic k1, k2, k3;
    k2 = 1'b1;
    i2c_start;
    send_byte(ctrl_of(wm, a, 1'b0), k1);
    if (wm) send_byte(a[15:8], k2);
    send_byte(a[7:0], k3);
    ok = k1 & k2 & k3;
  endtask

  task automatic poll_ready;
    logic k;
    int tries = 0;
    do begin
      i2c_start; send_byte(8'hA0, k); i2c_stop; tries++;
    end while (!k && tries < 40);
  endtask

  task automatic read_random(input logic wm, input logic [15:0] a, output logic [7:0] b);
    logic ok, k;
    addr_set(wm, a, ok);
    i2c_start; send_byte(ctrl_of(wm, a, 1'b1), k);
    get_byte(1'b0, b);
    i2c_stop;
  endtask

  task automatic read_current(output logic [7:0] b);
    logic k;
    i2c_start; send_byte(8'hA1, k); get_byte(1'b0, b); i2c_stop;
  endtask

  localparam logic [24:0] VEC [6] = '{
    {1'b1, 16'h0050, 8'h11}, {1'b1, 16'h0051, 8'h22}, {1'b0, 16'h0110, 8'h5A},
    {1'b1, 16'h03FF, 8'hE7}, {1'b0, 16'h0000, 8'h3C}, {1'b1, 16'h02C4, 8'h81}};

  initial begin
    logic ok, k, wm;
    logic [15:0] a;
    logic [7:0] d, b;
    int ei;

    repeat (5) @(negedge clk);
    check("R10 released after reset", {15'd0, sda_oe}, 16'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      {wm, a, d} = VEC[i];
      wide = wm;
      addr_set(wm, a, ok);
      send_byte(d, k);
      i2c_stop;
      check("R3 acks of byte write", {14'd0, ok, k}, 16'd3);
      poll_ready;
      read_random(wm, a, b);
      check("R2/R8 random read of written byte", {8'd0, b}, {8'd0, d});
    end

    // R2: narrow write of 0x110 seen through wide addressing
    wide = 1'b1;
    read_random(1'b1, 16'h0110, b);
    check("R2 narrow select bits extend address", {8'd0, b}, 16'h005A);

    // R7: current address follows random read
    read_random(1'b1, 16'h0050, b);
    read_current(b);
    check("R7 current address read", {8'd0, b}, 16'h0022);

    // R7 rollover and R9 sequential
    addr_set(1'b1, 16'h03FF, ok);
    i2c_start; send_byte(8'hA1, k);
    get_byte(1'b1, b);
    check("R9 first sequential byte", {8'd0, b}, 16'h00E7);
    get_byte(1'b0, b);
    check("R7 rollover to location 0", {8'd0, b}, 16'h003C);
    check("R9 SDA released after master nack", {15'd0, sda_oe}, 16'd0);
    i2c_stop;

    // R1: select mismatch in wide mode, then following byte ignored
    i2c_start; send_byte(8'hA2, k);
    check("R1 wide select mismatch nack", {15'd0, k}, 16'd0);
    send_byte(8'hA0, k);
    check("R1 bytes ignored after nack", {15'd0, k}, 16'd0);
    i2c_stop;
    wide = 1'b0;
    i2c_start; send_byte(8'hB0, k); i2c_stop;
    check("R1 wrong device code nack", {15'd0, k}, 16'd0);
    wide = 1'b1;

    // R4 page wrap with 18 bytes from 0x10E
    addr_set(1'b1, 16'h010E, ok);
    ei = 0;
    for (int i = 0; i < 18; i++) begin
      send_byte(8'h40 + 8'(i), k);
      if (!k) ei++;
    end
    i2c_stop;
    check("R3 acks of page write", 16'(ei), 16'd0);
    // R5: control byte during the write cycle
    i2c_start; send_byte(8'hA0, k); i2c_stop;
    check("R5 nack during write cycle", {15'd0, k}, 16'd0);
    poll_ready;
    addr_set(1'b1, 16'h0100, ok);
    i2c_start; send_byte(8'hA1, k);
    ei = 0;
    for (int kk = 0; kk < 16; kk++) begin
      int idx;
      get_byte(1'b1, b);
      idx = (kk + 2) % 16;
      if (idx + 16 < 18) idx += 16;
      if (b !== 8'h40 + 8'(idx)) begin
        ei++;
        $display("FAIL R4 page wrap at %0d: got %h expected %h", kk, b, 8'h40 + 8'(idx));
      end
    end
    checks++; if (ei != 0) errors++;
    get_byte(1'b0, b);
    i2c_stop;
    check("R4 next page untouched", {8'd0, b}, 16'h005A);

    // R6: stop mid-byte after a full data byte
    addr_set(1'b1, 16'h0050, ok);
    send_byte(8'h99, k);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    i2c_stop;
    i2c_start; send_byte(8'hA0, k); i2c_stop;
    check("R6 no write cycle after abort", {15'd0, k}, 16'd1);
    read_random(1'b1, 16'h0050, b);
    check("R6 memory kept after mid-byte stop", {8'd0, b}, 16'h0011);

    // R6: repeated start after write data
    addr_set(1'b1, 16'h0051, ok);
    send_byte(8'h77, k);
    i2c_start; send_byte(8'hA0, k); i2c_stop;
    check("R6 control acked after start abort", {15'd0, k}, 16'd1);
    read_random(1'b1, 16'h0051, b);
    check("R6 memory kept after repeated start", {8'd0, b}, 16'h0022);

    // R10: reset clears the counter, memory kept
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_current(b);
    check("R10 counter zero after reset", {8'd0, b}, 16'h003C);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule